// File: doc/BRIEF.md
# Flash Status Toggle Bit Generator

This block produces the status bits that a parallel NOR flash returns while an internal program or erase runs. A host polls the device with ordinary reads, and the returned status bits tell it whether the operation is still running. The status bits also say whether the device is suspended, which sectors are being erased and whether the operation ran out of time. A busy pull-down is provided so that several devices can share one ready line.

The block starts its own operations from single-cycle start strobes and times each one with a down-counter. A program or erase aimed only at protected sectors is not carried out: the block reports busy for a fixed short window and then goes back to array read. When no operation runs, the three status positions pass the array data through unchanged. A read cycle is the span in which both active-low strobes are low. Its start is the cycle in which both are first seen low.

Top module: `flash_toggle_status`

## Requirements
- R1: While a program, an erase, a program inside suspend or a protected-target window is active, `dq6` inverts after every read-cycle start, whatever the sector. A read cycle may be ended by `oe_n` alone or by `ce_n` alone.
- R2: With no operation active, `dq6`, `dq5` and `dq2` equal `arr_dq6`, `arr_dq5` and `arr_dq2` for every sector.
- R3: A `suspend_req` pulse during erase enters suspend, where `dq6` no longer toggles. A read of a sector in the erase set returns the frozen `dq6`, `dq5`=0 and the toggling `dq2`. A read of any other sector returns the three array bits. A `resume_req` pulse returns to erase.
- R4: During erase and during suspend, `dq2` inverts after each read-cycle start whose `rd_sector` lies in the erase set.
- R5: `dq2` never inverts on reads of sectors outside the erase set. It also never inverts during a program, a program inside suspend or a protected-target window.
- R6: In suspend, a `start_prog` pulse aimed at a sector that is neither in the erase set nor protected starts a program of `PROG_CYC` cycles and then returns to suspend. A pulse aimed at any other sector is ignored.
- R7: `rb_pull` is 1 during a program, an erase, a program inside suspend and a protected-target window, and 0 in idle, in suspend and in reset. A program keeps `rb_pull` high for exactly `PROG_CYC` cycles. An uninterrupted erase keeps it high for exactly `ERASE_CYC` cycles.
- R8: A program whose `prog_sector` bit is set in `prot_mask` does not program anything. `dq6` toggles for `CLK_MHZ` cycles (1 µs) and the block then goes idle.
- R9: An erase whose selected sectors are all protected reports busy with `dq6` toggling for `100*CLK_MHZ` cycles (100 µs) and then goes idle.
- R10: The erase set is `erase_sel & ~prot_mask`, captured at start, so protected selected sectors never toggle `dq2`. A `start_erase` pulse with `erase_sel` all zero is ignored.
- R11: If `op_fault` is 1 when a program or erase starts, the operation never completes. At the end of its normal duration `dq5` becomes 1, while `dq6` keeps toggling and `rb_pull` stays 1. Only then does a `reset_cmd` pulse return the block to idle. A `reset_cmd` pulse at any other time is ignored.
- R12: Start pulses that arrive while a program or erase is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_n | input | 1 | Active-low output-enable read strobe |
| ce_n | input | 1 | Active-low chip-enable read strobe |
| rd_sector | input | SEC_W | Sector decoded from the read address |
| start_prog | input | 1 | One-cycle program start (last command write) |
| start_erase | input | 1 | One-cycle erase start (last command write) |
| prog_sector | input | SEC_W | Sector targeted by the program |
| erase_sel | input | NSEC | Sectors selected for erase |
| prot_mask | input | NSEC | Protected sectors |
| op_fault | input | 1 | Sampled at start: the operation will not complete |
| suspend_req | input | 1 | One-cycle erase suspend request |
| resume_req | input | 1 | One-cycle erase resume request |
| reset_cmd | input | 1 | One-cycle reset command after a timeout |
| arr_dq6 | input | 1 | Array data bit 6 |
| arr_dq5 | input | 1 | Array data bit 5 |
| arr_dq2 | input | 1 | Array data bit 2 |
| dq6 | output | 1 | Operation toggle bit |
| dq5 | output | 1 | Timeout flag |
| dq2 | output | 1 | Erase-sector toggle bit |
| rb_pull | output | 1 | Pulls the shared ready line low when 1 |

## Verification
Reads go to random sectors, some inside the erase set, some in protected selected sectors and some unrelated. This separates the status bit that responds to any address from the one that responds only per sector. Reads are closed sometimes by one strobe and sometimes by the other, which shows that either strobe delimits a cycle. Busy windows are counted cycle by cycle for program, erase, protected program and fully protected erase, and each count must match its parameter exactly. Suspend, program inside suspend, rejected start pulses and the timeout path are driven in sequence. Those runs show that frozen and passed-through values are chosen by operation state and sector, not only by time.

// File: rtl/flash_tgl_pkg.sv
package flash_tgl_pkg;
    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PROG  = 3'd1,
        OP_ERASE = 3'd2,
        OP_SUSP  = 3'd3,
        OP_SPROG = 3'd4,
        OP_PROT  = 3'd5
    } op_e;

    function automatic logic op_toggles(op_e s);
        return (s == OP_PROG) || (s == OP_ERASE) || (s == OP_SPROG) || (s == OP_PROT);
    endfunction
endpackage

// File: rtl/rd_cycle_det.sv
module rd_cycle_det (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic ce_n,
    output logic rd_start
);
    typedef struct packed {
        logic act;
    } det_t;

    det_t det_d, det_q;
    logic act_now;

    always_comb begin
        act_now   = !oe_n && !ce_n;
        det_d.act = act_now;
        rd_start  = act_now && !det_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/op_sequencer.sv
module op_sequencer
    import flash_tgl_pkg::*;
#(
    parameter int NSEC           = 8,
    parameter int SEC_W          = 3,
    parameter int PROG_CYC       = 300,
    parameter int ERASE_CYC      = 5000,
    parameter int PROT_PROG_CYC  = 100,
    parameter int PROT_ERASE_CYC = 10000,
    parameter int CNT_W          = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_prog,
    input  logic             start_erase,
    input  logic [SEC_W-1:0] prog_sector,
    input  logic [NSEC-1:0]  erase_sel,
    input  logic [NSEC-1:0]  prot_mask,
    input  logic             op_fault,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic             reset_cmd,
    output op_e              state_o,
    output logic [NSEC-1:0]  set_o,
    output logic             tmo_o
);
    typedef struct packed {
        op_e              st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] scnt;
        logic [NSEC-1:0]  set;
        logic             fault;
        logic             tmo;
    } seq_t;

    localparam logic [CNT_W-1:0] PROG_LD   = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LD  = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PPROG_LD  = CNT_W'(PROT_PROG_CYC - 1);
    localparam logic [CNT_W-1:0] PERASE_LD = CNT_W'(PROT_ERASE_CYC - 1);

    seq_t seq_d, seq_q;
    logic [NSEC-1:0] eff_set;
    logic            tgt_prot;
    logic            tgt_in_set;

    assign eff_set    = erase_sel & ~prot_mask;
    assign tgt_prot   = prot_mask[prog_sector];
    assign tgt_in_set = seq_q.set[prog_sector];

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            OP_IDLE: begin
                if (start_prog) begin
                    seq_d.tmo = 1'b0;
                    if (tgt_prot) begin
                        seq_d.st    = OP_PROT;
                        seq_d.cnt   = PPROG_LD;
                        seq_d.fault = 1'b0;
                    end else begin
                        seq_d.st    = OP_PROG;
                        seq_d.cnt   = PROG_LD;
                        seq_d.fault = op_fault;
                    end
                end else if (start_erase && (|erase_sel)) begin
                    seq_d.tmo = 1'b0;
                    if (eff_set == '0) begin
                        seq_d.st    = OP_PROT;
                        seq_d.cnt   = PERASE_LD;
                        seq_d.set   = '0;
                        seq_d.fault = 1'b0;
                    end else begin
                        seq_d.st    = OP_ERASE;
                        seq_d.cnt   = ERASE_LD;
                        seq_d.set   = eff_set;
                        seq_d.fault = op_fault;
                    end
                end
            end
            OP_PROG, OP_ERASE: begin
                if (seq_q.tmo) begin
                    if (reset_cmd) begin
                        seq_d.st  = OP_IDLE;
                        seq_d.tmo = 1'b0;
                        seq_d.set = '0;
                    end
                end else if (seq_q.st == OP_ERASE && suspend_req) begin
                    seq_d.st = OP_SUSP;
                end else if (seq_q.cnt == '0) begin
                    if (seq_q.fault) begin
                        seq_d.tmo = 1'b1;
                    end else begin
                        seq_d.st  = OP_IDLE;
                        seq_d.set = '0;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            OP_SUSP: begin
                if (resume_req) begin
                    seq_d.st = OP_ERASE;
                end else if (start_prog && !tgt_in_set && !tgt_prot) begin
                    seq_d.st   = OP_SPROG;
                    seq_d.scnt = PROG_LD;
                end
            end
            OP_SPROG: begin
                if (seq_q.scnt == '0) seq_d.st = OP_SUSP;
                else                  seq_d.scnt = seq_q.scnt - 1'b1;
            end
            OP_PROT: begin
                if (seq_q.cnt == '0) seq_d.st = OP_IDLE;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            default: seq_d.st = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= OP_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.st;
    assign set_o   = seq_q.set;
    assign tmo_o   = seq_q.tmo;
endmodule

// File: rtl/toggle_bits.sv
module toggle_bits
    import flash_tgl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_start,
    input  op_e  st,
    input  logic in_set,
    input  logic tmo,
    input  logic arr_dq6,
    input  logic arr_dq5,
    input  logic arr_dq2,
    output logic dq6,
    output logic dq5,
    output logic dq2,
    output logic rb_pull
);
    typedef struct packed {
        logic t6;
        logic t2;
    } tgl_t;

    tgl_t tgl_d, tgl_q;
    logic busy_tgl;
    logic dq2_en;

    always_comb begin
        busy_tgl = op_toggles(st);
        dq2_en   = ((st == OP_ERASE) || (st == OP_SUSP)) && in_set;
        tgl_d    = tgl_q;
        if (rd_start && busy_tgl) tgl_d.t6 = ~tgl_q.t6;
        if (rd_start && dq2_en)   tgl_d.t2 = ~tgl_q.t2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= '0;
        else        tgl_q <= tgl_d;
    end

    always_comb begin
        rb_pull = busy_tgl;
        if (st == OP_IDLE || (st == OP_SUSP && !in_set)) begin
            dq6 = arr_dq6;
            dq5 = arr_dq5;
            dq2 = arr_dq2;
        end else if (st == OP_SUSP) begin
            dq6 = tgl_q.t6;
            dq5 = 1'b0;
            dq2 = tgl_q.t2;
        end else begin
            dq6 = tgl_q.t6;
            dq5 = tmo;
            dq2 = tgl_q.t2;
        end
    end
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
    import flash_tgl_pkg::*;
#(
    parameter int NSEC      = 8,
    parameter int CLK_MHZ   = 100,
    parameter int PROG_CYC  = 300,
    parameter int ERASE_CYC = 5000,
    localparam int SEC_W    = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oe_n,
    input  logic             ce_n,
    input  logic [SEC_W-1:0] rd_sector,
    input  logic             start_prog,
    input  logic             start_erase,
    input  logic [SEC_W-1:0] prog_sector,
    input  logic [NSEC-1:0]  erase_sel,
    input  logic [NSEC-1:0]  prot_mask,
    input  logic             op_fault,
    input  logic             suspend_req,
    input  logic             resume_req,
    input  logic             reset_cmd,
    input  logic             arr_dq6,
    input  logic             arr_dq5,
    input  logic             arr_dq2,
    output logic             dq6,
    output logic             dq5,
    output logic             dq2,
    output logic             rb_pull
);
    localparam int PROT_PROG_CYC  = CLK_MHZ;
    localparam int PROT_ERASE_CYC = CLK_MHZ * 100;
    localparam int MAX_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_B   = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    op_e             st_w;
    logic [NSEC-1:0] set_w;
    logic            tmo_w;
    logic            rd_start_w;
    logic            in_set_w;

    rd_cycle_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .ce_n     (ce_n),
        .rd_start (rd_start_w)
    );

    op_sequencer #(
        .NSEC           (NSEC),
        .SEC_W          (SEC_W),
        .PROG_CYC       (PROG_CYC),
        .ERASE_CYC      (ERASE_CYC),
        .PROT_PROG_CYC  (PROT_PROG_CYC),
        .PROT_ERASE_CYC (PROT_ERASE_CYC),
        .CNT_W          (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .prog_sector (prog_sector),
        .erase_sel   (erase_sel),
        .prot_mask   (prot_mask),
        .op_fault    (op_fault),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .reset_cmd   (reset_cmd),
        .state_o     (st_w),
        .set_o       (set_w),
        .tmo_o       (tmo_w)
    );

    assign in_set_w = set_w[rd_sector];

    toggle_bits u_tgl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start_w),
        .st       (st_w),
        .in_set   (in_set_w),
        .tmo      (tmo_w),
        .arr_dq6  (arr_dq6),
        .arr_dq5  (arr_dq5),
        .arr_dq2  (arr_dq2),
        .dq6      (dq6),
        .dq5      (dq5),
        .dq2      (dq2),
        .rb_pull  (rb_pull)
    );
endmodule

// File: rtl/flash_toggle_status_chk.sv
module flash_toggle_status_chk
    import flash_tgl_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input op_e  st,
    input logic rd_start,
    input logic in_set,
    input logic tmo,
    input logic reset_cmd,
    input logic dq6,
    input logic dq2,
    input logic rb_pull
);
    AST_DQ6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_toggles(st) && $past(op_toggles(st)) && $past(rd_start)) |-> (dq6 != $past(dq6))); // R1

    AST_SUSP_DQ6_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_SUSP && $past(st) == OP_SUSP && in_set && $past(in_set)) |-> $stable(dq6)); // R3

    AST_DQ2_SEL_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_ERASE && $past(st) == OP_ERASE && $past(rd_start) && $past(in_set)) |-> (dq2 != $past(dq2))); // R4

    AST_DQ2_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_ERASE && $past(st) == OP_ERASE && !($past(rd_start) && $past(in_set))) |-> $stable(dq2)); // R5

    AST_SUSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_SUSP) |-> !rb_pull); // R7

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !reset_cmd) |=> (tmo && rb_pull)); // R11
endmodule

bind flash_toggle_status flash_toggle_status_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_w),
    .rd_start  (rd_start_w),
    .in_set    (in_set_w),
    .tmo       (tmo_w),
    .reset_cmd (reset_cmd),
    .dq6       (dq6),
    .dq2       (dq2),
    .rb_pull   (rb_pull)
);

// File: tb/flash_toggle_status_tb_top.sv
module flash_toggle_status_tb_top;
    localparam int NSEC = 8;
    localparam int P    = 400;
    localparam int E    = 4000;
    localparam int PP   = 100;
    localparam int PE   = 10000;

    localparam int M_IDLE  = 0;
    localparam int M_PROG  = 1;
    localparam int M_ERASE = 2;
    localparam int M_SUSP  = 3;
    localparam int M_SPROG = 4;
    localparam int M_PROT  = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic oe_n = 1'b1, ce_n = 1'b1;
    logic [2:0] rd_sector = '0, prog_sector = '0;
    logic start_prog = 0, start_erase = 0, op_fault = 0;
    logic suspend_req = 0, resume_req = 0, reset_cmd = 0;
    logic [NSEC-1:0] erase_sel = '0, prot_mask = '0;
    logic arr_dq6 = 0, arr_dq5 = 0, arr_dq2 = 0;
    logic dq6, dq5, dq2, rb_pull;

    int checks = 0;
    int fails  = 0;
    int ms = M_IDLE;
    logic [NSEC-1:0] mset = '0;
    logic e6 = 1'b0, e2 = 1'b0, mtmo = 1'b0;

    flash_toggle_status #(.NSEC(NSEC), .CLK_MHZ(100), .PROG_CYC(P), .ERASE_CYC(E)) dut_i (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ce_n(ce_n), .rd_sector(rd_sector),
        .start_prog(start_prog), .start_erase(start_erase), .prog_sector(prog_sector),
        .erase_sel(erase_sel), .prot_mask(prot_mask), .op_fault(op_fault),
        .suspend_req(suspend_req), .resume_req(resume_req), .reset_cmd(reset_cmd),
        .arr_dq6(arr_dq6), .arr_dq5(arr_dq5), .arr_dq2(arr_dq2),
        .dq6(dq6), .dq5(dq5), .dq2(dq2), .rb_pull(rb_pull)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic tgl_state(int s);
        return (s == M_PROG) || (s == M_ERASE) || (s == M_SPROG) || (s == M_PROT);
    endfunction

    function automatic logic x6(int s);
        if (ms == M_IDLE) return arr_dq6;
        if (ms == M_SUSP) return mset[s] ? e6 : arr_dq6;
        return e6;
    endfunction

    function automatic logic x5(int s);
        if (ms == M_IDLE) return arr_dq5;
        if (ms == M_SUSP) return mset[s] ? 1'b0 : arr_dq5;
        return mtmo;
    endfunction

    function automatic logic x2(int s);
        if (ms == M_IDLE) return arr_dq2;
        if (ms == M_SUSP) return mset[s] ? e2 : arr_dq2;
        return e2;
    endfunction

    task automatic do_read(int sec, string req);
        @(negedge clk);
        rd_sector = 3'(sec);
        {arr_dq6, arr_dq5, arr_dq2} = 3'($urandom);
        oe_n = 1'b0;
        ce_n = 1'b0;
        if (tgl_state(ms)) e6 = ~e6;
        if ((ms == M_ERASE || ms == M_SUSP) && mset[sec]) e2 = ~e2;
        @(negedge clk);
        chk({req, " dq6"}, int'(dq6), int'(x6(sec)));
        chk({req, " dq2"}, int'(dq2), int'(x2(sec)));
        chk({req, " dq5"}, int'(dq5), int'(x5(sec)));
        case ($urandom % 3)
            0: oe_n = 1'b1;
            1: ce_n = 1'b1;
            default: begin oe_n = 1'b1; ce_n = 1'b1; end
        endcase
        @(negedge clk);
    endtask

    task automatic rand_reads(int n, string req);
        for (int i = 0; i < n; i++) do_read(int'($urandom % NSEC), req);
    endtask

    task automatic p_prog(int sec);
        @(negedge clk); prog_sector = 3'(sec); start_prog = 1'b1;
        @(negedge clk); start_prog = 1'b0;
    endtask
    task automatic p_erase();
        @(negedge clk); start_erase = 1'b1;
        @(negedge clk); start_erase = 1'b0;
    endtask
    task automatic p_susp();
        @(negedge clk); suspend_req = 1'b1;
        @(negedge clk); suspend_req = 1'b0;
    endtask
    task automatic p_resume();
        @(negedge clk); resume_req = 1'b1;
        @(negedge clk); resume_req = 1'b0;
    endtask
    task automatic p_rst();
        @(negedge clk); reset_cmd = 1'b1;
        @(negedge clk); reset_cmd = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (rb_pull && n < 30000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R7 reset rb_pull", int'(rb_pull), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 idle rb_pull", int'(rb_pull), 0);
        rand_reads(4, "R2 idle passthrough");

        // program: exact busy length
        p_prog(2); ms = M_PROG;
        wait_busy(n); chk("R7 program length", n, P); ms = M_IDLE;

        // program with reads, erase start ignored
        p_prog(5); ms = M_PROG;
        rand_reads(5, "R1 program toggle");
        erase_sel = 8'hFF; p_erase();
        rand_reads(6, "R12 erase ignored while programming");
        chk("R12 still busy", int'(rb_pull), 1);
        wait_busy(n); ms = M_IDLE;
        rand_reads(3, "R2 after program");

        // erase: exact busy length
        erase_sel = 8'h0F; prot_mask = '0;
        p_erase(); ms = M_ERASE; mset = 8'h0F;
        wait_busy(n); chk("R7 erase length", n, E); ms = M_IDLE; mset = '0;

        // erase with partial protection, suspend, program in suspend
        erase_sel = 8'b0011_1100; prot_mask = 8'b0000_1100;
        p_erase(); ms = M_ERASE; mset = 8'b0011_0000;
        rand_reads(16, "R4 R5 R10 erase reads");
        do_read(2, "R10 protected selected sector");
        do_read(4, "R4 selected sector");
        p_prog(1);
        chk("R12 prog during erase ignored", int'(rb_pull), 1);
        do_read(1, "R12 no program started");
        p_susp(); ms = M_SUSP;
        chk("R7 suspend released", int'(rb_pull), 0);
        rand_reads(10, "R3 suspend reads");
        do_read(5, "R3 frozen dq6 in set");
        do_read(5, "R3 frozen dq6 in set again");
        p_prog(4);
        chk("R6 program into erase set ignored", int'(rb_pull), 0);
        p_prog(3);
        chk("R6 program into protected ignored", int'(rb_pull), 0);
        p_prog(7); ms = M_SPROG;
        chk("R6 program in suspend busy", int'(rb_pull), 1);
        rand_reads(6, "R6 R5 suspend program reads");
        wait_busy(n); ms = M_SUSP;
        chk("R6 back to suspend", int'(rb_pull), 0);
        rand_reads(4, "R3 suspend again");
        p_resume(); ms = M_ERASE;
        chk("R3 resumed busy", int'(rb_pull), 1);
        rand_reads(6, "R4 after resume");
        wait_busy(n); ms = M_IDLE; mset = '0;
        rand_reads(3, "R2 after erase");

        // protected program
        prot_mask = 8'h80;
        p_prog(7); ms = M_PROT;
        wait_busy(n); chk("R8 protected program length", n, PP); ms = M_IDLE;
        p_prog(7); ms = M_PROT;
        rand_reads(6, "R8 R5 protected program toggles");
        wait_busy(n); ms = M_IDLE;

        // fully protected erase
        erase_sel = 8'h80;
        p_erase(); ms = M_PROT;
        wait_busy(n); chk("R9 protected erase length", n, PE); ms = M_IDLE;
        rand_reads(2, "R2 after protected erase");

        // empty selection
        erase_sel = '0;
        p_erase();
        chk("R10 empty selection ignored", int'(rb_pull), 0);
        rand_reads(2, "R10 still idle");

        // timeout path
        prot_mask = '0; op_fault = 1'b1;
        p_prog(1); ms = M_PROG;
        op_fault = 1'b0;
        p_rst();
        chk("R11 early reset ignored", int'(rb_pull), 1);
        repeat (P + 10) @(negedge clk);
        mtmo = 1'b1;
        chk("R11 busy after timeout", int'(rb_pull), 1);
        rand_reads(5, "R11 timeout reads");
        p_rst(); ms = M_IDLE; mtmo = 1'b0;
        chk("R11 reset returns idle", int'(rb_pull), 0);
        rand_reads(3, "R11 R2 idle after reset");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule